// File: doc/BRIEF.md
# Split-Transaction Tagged Bus Master

This block drives a system bus whose address and data tenures are decoupled. A scheduler hands it one request at a time: an operation kind, an address and the identity of the requester. The block gives the request a bus tag, asks for the address bus, waits for the grant, and then drives one address-phase cycle that carries the kind, the tag and the address. It does not wait for that transaction's data. Once the address bus is free again it takes the next request. Up to eight transactions can be in flight at once.

Data phases come back on their own, each labelled with a tag, in whatever order the responding devices finish. A slow device therefore never holds up a fast one. The returned tag selects the stored entry. The block then completes the transaction to its requester, with the kind, the tag and the returned data, and the tag goes back into the pool. A return whose tag matches no transaction in flight raises an error pulse and changes nothing else.

Top module: `split_bus_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req`, `ap_valid`, `cpl_valid` and `err_bad_tag` are low and `req_ready` is high.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. From the next cycle `bus_req` is high and stays high while `bus_gnt` is low. In the cycle after one in which `bus_req` and `bus_gnt` are both high, `ap_valid` is high for exactly one cycle and `bus_req` is low.
- R3: The address phase carries the accepted kind on `ap_kind` (0 read, 1 write, 2 read-modify-write, 3 cache invalidate), the accepted address on `ap_addr`, and on `ap_tag` the lowest-numbered tag that was free when the request was accepted.
- R4: `req_ready` is high whenever the address sequencer is idle and at least one tag is free, even while other transactions are waiting for data.
- R5: When all 8 tags are in use, `req_ready` stays low and no bus request or address phase is started.
- R6: A data return whose tag has finished its address phase and is still in flight produces, one cycle later, a one-cycle `cpl_valid` with that transaction's requester on `cpl_src`, its kind, its tag and the returned data. The tag becomes free at that point.
- R7: Data returns complete correctly in any order relative to their address phases.
- R8: A data return whose tag is not in flight gives a one-cycle `err_bad_tag` pulse one cycle later, with no completion, and leaves the tag state unchanged.
- R9: A tag freed by a completion can be allocated again, and allocation always picks the lowest free tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler offers a request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | Operation kind: 0 read, 1 write, 2 read-modify-write, 3 cache invalidate |
| req_addr | input | 32 | Target address |
| req_src | input | 2 | Requester identity returned with the completion |
| bus_req | output | 1 | Address-bus request |
| bus_gnt | input | 1 | Address-bus grant |
| ap_valid | output | 1 | Address phase on the bus this cycle |
| ap_kind | output | 2 | Operation kind of the address phase |
| ap_tag | output | 3 | Bus tag of the address phase |
| ap_addr | output | 32 | Address of the address phase |
| dr_valid | input | 1 | Data return present |
| dr_tag | input | 3 | Tag of the returning data |
| dr_data | input | 32 | Returned data |
| cpl_valid | output | 1 | Completion to a requester |
| cpl_src | output | 2 | Requester the completion belongs to |
| cpl_kind | output | 2 | Operation kind of the completed transaction |
| cpl_tag | output | 3 | Tag of the completed transaction |
| cpl_data | output | 32 | Data delivered with the completion |
| err_bad_tag | output | 1 | Data return carried a tag not in flight |

## Verification
The assertions rely on the bus keeping its side of the protocol. The grant is only sampled while the request is up, and a data return never names a tag before that tag's address phase has ended. Under those conditions, a tag that is about to be issued is never already marked outstanding in the checker's own map. The stimulus holds the grant low for zero to three cycles and raises it for a single cycle only while `bus_req` is high. It returns data only for tags whose address phase it has observed, with one exception: the deliberate returns of tags that are already free, used to exercise the error path. Each round uses a different odd stride to produce its return order, so every tag is completed out of order more than once.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_RMW   = 2'd2,
        KIND_INVAL = 2'd3
    } xact_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARB  = 2'd1,
        PH_ADDR = 2'd2
    } aphase_e;

endpackage

// File: rtl/sbm_tag_pool.sv
`timescale 1ns/1ps
module sbm_tag_pool #(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             rel_en,
    input  logic [TAG_W-1:0] rel_tag,
    output logic             any_free,
    output logic [TAG_W-1:0] pick_tag
);
    localparam int NTAGS = 1 << TAG_W;

    typedef struct packed {
        logic [NTAGS-1:0] busy;
    } pool_s;

    pool_s st_d, st_q;

    always_comb begin
        pick_tag = '0;
        any_free = 1'b0;
        for (int i = NTAGS - 1; i >= 0; i--) begin
            if (!st_q.busy[i]) begin
                pick_tag = TAG_W'(i);
                any_free = 1'b1;
            end
        end

        st_d = st_q;
        if (rel_en) begin
            st_d.busy[rel_tag] = 1'b0;
        end
        if (alloc_en && any_free) begin
            st_d.busy[pick_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sbm_addr_ctrl.sv
`timescale 1ns/1ps
module sbm_addr_ctrl
    import sbm_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [1:0]        take_kind,
    input  logic [ADDR_W-1:0] take_addr,
    input  logic [TAG_W-1:0]  take_tag,
    input  logic              bus_gnt,
    output logic              idle,
    output logic              bus_req,
    output logic              ap_valid,
    output logic [1:0]        ap_kind,
    output logic [TAG_W-1:0]  ap_tag,
    output logic [ADDR_W-1:0] ap_addr
);
    typedef struct packed {
        aphase_e           phase;
        logic [1:0]        kind;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (take) begin
                    st_d.phase = PH_ARB;
                    st_d.kind  = take_kind;
                    st_d.tag   = take_tag;
                    st_d.addr  = take_addr;
                end
            end
            PH_ARB: begin
                if (bus_gnt) begin
                    st_d.phase = PH_ADDR;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle     = (st_q.phase == PH_IDLE);
    assign bus_req  = (st_q.phase == PH_ARB);
    assign ap_valid = (st_q.phase == PH_ADDR);
    assign ap_kind  = st_q.kind;
    assign ap_tag   = st_q.tag;
    assign ap_addr  = st_q.addr;

endmodule

// File: rtl/sbm_txn_table.sv
`timescale 1ns/1ps
module sbm_txn_table #(
    parameter int TAG_W  = 3,
    parameter int SRC_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic [1:0]        wr_kind,
    input  logic              iss_en,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              dr_valid,
    input  logic [TAG_W-1:0]  dr_tag,
    input  logic [DATA_W-1:0] dr_data,
    output logic              rel_en,
    output logic [TAG_W-1:0]  rel_tag,
    output logic              cpl_valid,
    output logic [SRC_W-1:0]  cpl_src,
    output logic [1:0]        cpl_kind,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic              bad_tag
);
    localparam int NTAGS = 1 << TAG_W;

    typedef struct packed {
        logic             live;
        logic [SRC_W-1:0] src;
        logic [1:0]       kind;
    } entry_s;

    typedef struct packed {
        entry_s [NTAGS-1:0] ent;
        logic               cv;
        logic [SRC_W-1:0]   csrc;
        logic [1:0]         ckind;
        logic [TAG_W-1:0]   ctag;
        logic [DATA_W-1:0]  cdata;
        logic               bad;
    } tbl_s;

    tbl_s st_d, st_q;
    logic hit;

    always_comb begin
        hit  = dr_valid && st_q.ent[dr_tag].live;
        st_d = st_q;
        st_d.cv  = 1'b0;
        st_d.bad = 1'b0;

        if (hit) begin
            st_d.cv                = 1'b1;
            st_d.csrc              = st_q.ent[dr_tag].src;
            st_d.ckind             = st_q.ent[dr_tag].kind;
            st_d.ctag              = dr_tag;
            st_d.cdata             = dr_data;
            st_d.ent[dr_tag].live  = 1'b0;
        end else if (dr_valid) begin
            st_d.bad = 1'b1;
        end

        if (wr_en) begin
            st_d.ent[wr_tag].live = 1'b0;
            st_d.ent[wr_tag].src  = wr_src;
            st_d.ent[wr_tag].kind = wr_kind;
        end
        if (iss_en) begin
            st_d.ent[iss_tag].live = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_en    = hit;
    assign rel_tag   = dr_tag;
    assign cpl_valid = st_q.cv;
    assign cpl_src   = st_q.csrc;
    assign cpl_kind  = st_q.ckind;
    assign cpl_tag   = st_q.ctag;
    assign cpl_data  = st_q.cdata;
    assign bad_tag   = st_q.bad;

endmodule

// File: rtl/split_bus_master.sv
`timescale 1ns/1ps
module split_bus_master #(
    parameter int TAG_W  = 3,
    parameter int SRC_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SRC_W-1:0]  req_src,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              ap_valid,
    output logic [1:0]        ap_kind,
    output logic [TAG_W-1:0]  ap_tag,
    output logic [ADDR_W-1:0] ap_addr,
    input  logic              dr_valid,
    input  logic [TAG_W-1:0]  dr_tag,
    input  logic [DATA_W-1:0] dr_data,
    output logic              cpl_valid,
    output logic [SRC_W-1:0]  cpl_src,
    output logic [1:0]        cpl_kind,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic              err_bad_tag
);
    logic             seq_idle;
    logic             tags_avail;
    logic [TAG_W-1:0] next_tag;
    logic             accept;
    logic             rel_en;
    logic [TAG_W-1:0] rel_tag;

    assign req_ready = seq_idle && tags_avail;
    assign accept    = req_valid && req_ready;

    sbm_tag_pool #(.TAG_W(TAG_W)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (accept),
        .rel_en   (rel_en),
        .rel_tag  (rel_tag),
        .any_free (tags_avail),
        .pick_tag (next_tag)
    );

    sbm_addr_ctrl #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .take_kind (req_kind),
        .take_addr (req_addr),
        .take_tag  (next_tag),
        .bus_gnt   (bus_gnt),
        .idle      (seq_idle),
        .bus_req   (bus_req),
        .ap_valid  (ap_valid),
        .ap_kind   (ap_kind),
        .ap_tag    (ap_tag),
        .ap_addr   (ap_addr)
    );

    sbm_txn_table #(.TAG_W(TAG_W), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_tag    (next_tag),
        .wr_src    (req_src),
        .wr_kind   (req_kind),
        .iss_en    (ap_valid),
        .iss_tag   (ap_tag),
        .dr_valid  (dr_valid),
        .dr_tag    (dr_tag),
        .dr_data   (dr_data),
        .rel_en    (rel_en),
        .rel_tag   (rel_tag),
        .cpl_valid (cpl_valid),
        .cpl_src   (cpl_src),
        .cpl_kind  (cpl_kind),
        .cpl_tag   (cpl_tag),
        .cpl_data  (cpl_data),
        .bad_tag   (err_bad_tag)
    );

endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
module sbm_checker #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             ap_valid,
    input logic [TAG_W-1:0] ap_tag,
    input logic             dr_valid,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             err_bad_tag
);
    localparam int NTAGS = 1 << TAG_W;

    logic [TAG_W:0]     live_cnt;
    logic [NTAGS-1:0]   out_map;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
            out_map  <= '0;
        end else begin
            live_cnt <= live_cnt + (TAG_W+1)'(req_valid && req_ready)
                                 - (TAG_W+1)'(cpl_valid);
            for (int i = 0; i < NTAGS; i++) begin
                if (ap_valid && (ap_tag == TAG_W'(i))) out_map[i] <= 1'b1;
                else if (cpl_valid && (cpl_tag == TAG_W'(i))) out_map[i] <= 1'b0;
            end
        end
    end

    AST_ACCEPT_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> bus_req);                              // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && !ap_valid);                    // R2
    AST_GNT_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |=> ap_valid && !bus_req);                     // R2
    AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid |=> !ap_valid);                                          // R2
    AST_TAG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid |-> !out_map[ap_tag]);                                   // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == (TAG_W+1)'(NTAGS)) && !cpl_valid |-> !req_ready);    // R5
    AST_CPL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> out_map[cpl_tag]);                                  // R6
    AST_CPL_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_valid && err_bad_tag));                                     // R8
    AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid || err_bad_tag) |-> $past(dr_valid));                  // R8

endmodule

bind split_bus_master sbm_checker #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .ap_valid    (ap_valid),
    .ap_tag      (ap_tag),
    .dr_valid    (dr_valid),
    .cpl_valid   (cpl_valid),
    .cpl_tag     (cpl_tag),
    .err_bad_tag (err_bad_tag)
);

// File: tb/tb_split_bus_master.sv
`timescale 1ns/1ps
module tb_split_bus_master;
    localparam int TAG_W  = 3;
    localparam int NT     = 1 << TAG_W;
    localparam int SRC_W  = 2;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              req_valid, req_ready;
    logic [1:0]        req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic [SRC_W-1:0]  req_src;
    logic              bus_req, bus_gnt;
    logic              ap_valid;
    logic [1:0]        ap_kind;
    logic [TAG_W-1:0]  ap_tag;
    logic [ADDR_W-1:0] ap_addr;
    logic              dr_valid;
    logic [TAG_W-1:0]  dr_tag;
    logic [DATA_W-1:0] dr_data;
    logic              cpl_valid;
    logic [SRC_W-1:0]  cpl_src;
    logic [1:0]        cpl_kind;
    logic [TAG_W-1:0]  cpl_tag;
    logic [DATA_W-1:0] cpl_data;
    logic              err_bad_tag;

    split_bus_master dut (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit               m_busy [NT];
    logic [SRC_W-1:0] m_src  [NT];
    logic [1:0]       m_kind [NT];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < NT; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    task automatic issue(input logic [1:0] kind, input logic [ADDR_W-1:0] addr,
                         input logic [SRC_W-1:0] src, input int gdelay);
        int t;
        t = low_free();
        @(negedge clk);
        chk("R4", "req_ready", 64'(req_ready), 64'(t >= 0));
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "bus_req after accept", 64'(bus_req), 64'd1);
        chk("R2", "ap_valid before grant", 64'(ap_valid), 64'd0);
        for (int d = 0; d < gdelay; d++) begin
            @(negedge clk);
            chk("R2", "bus_req held", 64'(bus_req), 64'd1);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk("R2", "ap_valid after grant", 64'(ap_valid), 64'd1);
        chk("R2", "bus_req dropped", 64'(bus_req), 64'd0);
        chk("R3", "ap_tag lowest free", 64'(ap_tag), 64'(t));
        chk("R3", "ap_kind", 64'(ap_kind), 64'(kind));
        chk("R3", "ap_addr", 64'(ap_addr), 64'(addr));
        m_busy[t] = 1'b1; m_src[t] = src; m_kind[t] = kind;
        @(negedge clk);
        chk("R2", "ap_valid single cycle", 64'(ap_valid), 64'd0);
    endtask

    task automatic ret(input string req, input int tag, input logic [DATA_W-1:0] data);
        bit ok;
        ok = m_busy[tag];
        @(negedge clk);
        dr_valid = 1'b1; dr_tag = TAG_W'(tag); dr_data = data;
        @(negedge clk);
        dr_valid = 1'b0;
        chk(req, "cpl_valid", 64'(cpl_valid), 64'(ok));
        if (ok) begin
            chk(req, "cpl_src", 64'(cpl_src), 64'(m_src[tag]));
            chk(req, "cpl_kind", 64'(cpl_kind), 64'(m_kind[tag]));
            chk(req, "cpl_tag", 64'(cpl_tag), 64'(tag));
            chk(req, "cpl_data", 64'(cpl_data), 64'(data));
            chk(req, "no error", 64'(err_bad_tag), 64'd0);
            m_busy[tag] = 1'b0;
        end else begin
            chk("R8", "err_bad_tag", 64'(err_bad_tag), 64'd1);
        end
        @(negedge clk);
        chk(req, "one-cycle response", 64'({cpl_valid, err_bad_tag}), 64'd0);
    endtask

    task automatic full_stall();
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'hDEAD_0000; req_src = 2'd3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5", "req_ready when full", 64'(req_ready), 64'd0);
            chk("R5", "no bus activity", 64'({bus_req, ap_valid}), 64'd0);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_src = '0;
        bus_gnt = 1'b0; dr_valid = 1'b0; dr_tag = '0; dr_data = '0;
        for (int i = 0; i < NT; i++) m_busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", 64'({bus_req, ap_valid, cpl_valid, err_bad_tag}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk("R1", "outputs after reset", 64'({bus_req, ap_valid, cpl_valid, err_bad_tag}), 64'd0);

        for (int r = 0; r < 4; r++) begin
            int p;
            p = 2 * r + 1;
            for (int i = 0; i < NT; i++)
                issue(2'((i + r) % 4), 32'h1000 * r + 32'(i * 4), 2'(i % 4), (i + r) % 4);
            full_stall();
            for (int i = 0; i < NT; i++) begin
                int tag;
                tag = (i * p + r) % NT;
                ret("R7", tag, 32'hA000_0000 | 32'(r << 8) | 32'(tag));
                if (i == 0) begin
                    ret("R8", tag, 32'hBAD0_0000);
                    issue(2'd3, 32'hC000_0000 | 32'(r), 2'd2, 0);
                    ret("R9", tag, 32'h5555_0000 | 32'(r));
                end
                if (i == 2) begin
                    int lt;
                    lt = low_free();
                    issue(2'd2, 32'hE000_0000 | 32'(r), 2'd1, 1);
                    ret("R9", lt, 32'h7777_0000 | 32'(r));
                end
            end
            ret("R6", r, 32'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule